// File: doc/BRIEF.md
# Strobed Serial Configuration Port

This block is the slave side of a slow serial configuration link. An external controller presents one bit at a time on a data pin and marks each bit with a rising edge on a strobe pin. Both pins are brought into the system clock domain through two-flop synchronizers, and all shifting happens on the detected rising edge of the synchronized strobe. Because the shift path is a plain shift register with no timeout, the strobe may run as slowly as the controller likes.

A frame is sixteen data bits, most significant first, followed by four trailing strobe pulses that carry no data and commit the word. A committed word waits in a single holding slot until an internal poll tick, generated every `POLL_TICKS` system clocks, moves it into one of six parallel configuration registers. The four lowest bits of the word form the register address and the twelve upper bits form the stored value. A ready output goes low while a committed word waits and returns high once the poll has consumed it. If the controller commits a second word before the poll, the second word replaces the first in the slot and the first is lost.

Top module: `scp_cfg_port`

## Requirements
- R1: After reset every register field on `cfg_o` equals its slice of `RESET_VALS` (register k at bits k*12+11..k*12) and `drdy_o` is high.
- R2: Data is sampled on each synchronized strobe rising edge, most significant bit first; a committed word w stores w[15:4] into the register selected by w[3:0].
- R3: A word is committed only on the twentieth strobe pulse of a frame; after nineteen pulses `drdy_o` stays high and no register changes.
- R4: `drdy_o` falls after a commit, stays low until the next poll tick, and rises right after that tick.
- R5: Registers change only one cycle after a poll tick, and poll ticks are exactly `POLL_TICKS` system clocks apart; a committed word is not visible on `cfg_o` before the tick.
- R6: Address values 0, 2, 4, 6, 8 and 10 select registers 0 to 5; a word whose address has bit 0 set or is 12 or above is dropped with no register change, while `drdy_o` still falls and rises.
- R7: A word committed while an earlier word still waits replaces it; only the later word reaches the register bank and `drdy_o` falls only once for both.
- R8: A transfer changes at most one register; all other fields keep their values.
- R9: Strobe high and low phases of any length of at least three system clocks each give the same result as fast strobing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Asynchronous serial strobe, rising edge marks a bit |
| data_i | input | 1 | Asynchronous serial data bit |
| drdy_o | output | 1 | High when no committed word is waiting for the poll |
| cfg_o | output | NUM_REGS*12 | All configuration register fields, register k in bits k*12+11..k*12 |

## Verification
The assertions assume the strobe and data pins obey the pulse-width rule: each strobe phase lasts long enough to pass the synchronizer, and data is stable across the synchronized rising edge. The stimulus drives data during the strobe low phase and holds every phase for at least four system clocks, changing pins only on the falling clock edge. The overwrite scenario aligns to a ready rising edge, so the bench knows the poll phase and can place two commits inside one poll period.

// File: rtl/scp_pkg.sv
package scp_pkg;

    // Frame geometry shared by every part of the port.
    localparam int unsigned WORD_W       = 16;
    localparam int unsigned ADDR_W       = 4;
    localparam int unsigned FIELD_W      = WORD_W - ADDR_W;
    localparam int unsigned TRAIL_PULSES = 4;
    localparam int unsigned FRAME_PULSES = WORD_W + TRAIL_PULSES;
    localparam int unsigned PULSE_CNT_W  = $clog2(FRAME_PULSES + 1);

    typedef logic [WORD_W-1:0]      word_t;
    typedef logic [FIELD_W-1:0]     field_t;
    typedef logic [ADDR_W-1:0]      addr_t;
    typedef logic [PULSE_CNT_W-1:0] pulse_cnt_t;

    function automatic addr_t word_addr(input word_t w);
        return w[ADDR_W-1:0];
    endfunction

    function automatic field_t word_field(input word_t w);
        return w[WORD_W-1:ADDR_W];
    endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = async_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            st_d.stage[s] = st_q.stage[s-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stage[STAGES-1];

endmodule

// File: rtl/scp_shifter.sv
module scp_shifter
    import scp_pkg::*;
#(
    parameter int unsigned DATA_PULSES  = WORD_W,
    parameter int unsigned EXTRA_PULSES = TRAIL_PULSES
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  strobe_s_i,
    input  logic  data_s_i,
    output logic  commit_o,
    output word_t word_o
);

    localparam int unsigned LAST_PULSE = DATA_PULSES + EXTRA_PULSES;

    typedef struct packed {
        logic       strobe_prev;
        pulse_cnt_t count;
        word_t      shreg;
        logic       commit;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic         rise;

    assign rise = strobe_s_i & ~st_q.strobe_prev;

    always_comb begin
        st_d             = st_q;
        st_d.strobe_prev = strobe_s_i;
        st_d.commit      = 1'b0;
        if (rise) begin
            // Data positions come first, then the trailing commit pulses.
            if (int'(st_q.count) < int'(DATA_PULSES)) begin
                st_d.shreg = {st_q.shreg[WORD_W-2:0], data_s_i};
            end
            if (int'(st_q.count) == int'(LAST_PULSE) - 1) begin
                st_d.count  = '0;
                st_d.commit = 1'b1;
            end else begin
                st_d.count = st_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_o = st_q.commit;
    assign word_o   = st_q.shreg;

endmodule

// File: rtl/scp_poll_timer.sv
module scp_poll_timer #(
    parameter int unsigned POLL_TICKS = 12500
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);

    localparam int unsigned TCNT_W = $clog2(POLL_TICKS + 1);

    typedef struct packed {
        logic [TCNT_W-1:0] cnt;
    } timer_state_t;

    timer_state_t st_d, st_q;
    logic         at_end;

    assign at_end = (st_q.cnt == TCNT_W'(POLL_TICKS - 1));

    always_comb begin
        st_d = st_q;
        if (at_end) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = at_end;

endmodule

// File: rtl/scp_reg_bank.sv
module scp_reg_bank
    import scp_pkg::*;
#(
    parameter int unsigned              NUM_REGS   = 6,
    parameter logic [NUM_REGS*FIELD_W-1:0] RESET_VALS = '0
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        commit_i,
    input  word_t                       word_i,
    input  logic                        tick_i,
    output logic                        drdy_o,
    output logic [NUM_REGS*FIELD_W-1:0] regs_o
);

    typedef struct packed {
        word_t                            pend_word;
        logic                             pend_valid;
        logic [NUM_REGS-1:0][FIELD_W-1:0] regs;
    } bank_state_t;

    bank_state_t          st_d, st_q;
    addr_t                pend_addr;
    int unsigned          pend_idx;
    logic                 addr_ok;
    logic                 xfer;
    logic [NUM_REGS-1:0]  wr_en;

    assign pend_addr = word_addr(st_q.pend_word);
    assign pend_idx  = int'(pend_addr >> 1);
    assign addr_ok   = ~pend_addr[0] && (pend_idx < NUM_REGS);
    assign xfer      = tick_i & st_q.pend_valid;

    for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_wr_en
        assign wr_en[g] = xfer && addr_ok && (pend_idx == g);
    end

    always_comb begin
        st_d = st_q;
        // The poll consumes the slot; a fresh commit in the same cycle refills it.
        if (xfer) begin
            st_d.pend_valid = 1'b0;
        end
        if (commit_i) begin
            st_d.pend_word  = word_i;
            st_d.pend_valid = 1'b1;
        end
        for (int i = 0; i < int'(NUM_REGS); i++) begin
            if (wr_en[i]) begin
                st_d.regs[i] = word_field(st_q.pend_word);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.pend_word  <= '0;
            st_q.pend_valid <= 1'b0;
            st_q.regs       <= RESET_VALS;
        end else begin
            st_q <= st_d;
        end
    end

    assign drdy_o = ~st_q.pend_valid;
    assign regs_o = st_q.regs;

endmodule

// File: rtl/scp_cfg_port.sv
module scp_cfg_port
    import scp_pkg::*;
#(
    parameter int unsigned                 NUM_REGS   = 6,
    parameter int unsigned                 POLL_TICKS = 12500,
    parameter logic [NUM_REGS*FIELD_W-1:0] RESET_VALS =
        {12'h5A0, 12'h0C3, 12'h214, 12'h008, 12'h3F0, 12'h101}
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        strobe_i,
    input  logic                        data_i,
    output logic                        drdy_o,
    output logic [NUM_REGS*FIELD_W-1:0] cfg_o
);

    logic  strobe_s;
    logic  data_s;
    logic  commit;
    word_t word;
    logic  poll_tick;

    scp_sync #(
        .WIDTH (2),
        .STAGES(2)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i({strobe_i, data_i}),
        .sync_o ({strobe_s, data_s})
    );

    scp_shifter #(
        .DATA_PULSES (WORD_W),
        .EXTRA_PULSES(TRAIL_PULSES)
    ) u_shifter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .strobe_s_i(strobe_s),
        .data_s_i  (data_s),
        .commit_o  (commit),
        .word_o    (word)
    );

    scp_poll_timer #(
        .POLL_TICKS(POLL_TICKS)
    ) u_timer (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_o(poll_tick)
    );

    scp_reg_bank #(
        .NUM_REGS  (NUM_REGS),
        .RESET_VALS(RESET_VALS)
    ) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .commit_i(commit),
        .word_i  (word),
        .tick_i  (poll_tick),
        .drdy_o  (drdy_o),
        .regs_o  (cfg_o)
    );

endmodule

// File: rtl/scp_cfg_port_chk.sv
module scp_cfg_port_chk
    import scp_pkg::*;
#(
    parameter int unsigned NUM_REGS   = 6,
    parameter int unsigned POLL_TICKS = 12500
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        drdy_o,
    input logic [NUM_REGS*FIELD_W-1:0] cfg_o,
    input logic                        poll_tick,
    input logic                        commit
);

    localparam int unsigned GAP_W = $clog2(POLL_TICKS + 1);

    logic [NUM_REGS*FIELD_W-1:0] prev_q;
    logic                        seen_q;
    logic [GAP_W-1:0]            gap_q;
    logic [NUM_REGS-1:0]         changed;

    always_ff @(posedge clk_i) begin
        prev_q <= cfg_o;
        if (!rst_ni) begin
            seen_q <= 1'b0;
            gap_q  <= '0;
        end else begin
            seen_q <= 1'b1;
            gap_q  <= poll_tick ? '0 : gap_q + 1'b1;
        end
    end

    for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_chg
        assign changed[g] = (cfg_o[g*FIELD_W +: FIELD_W] != prev_q[g*FIELD_W +: FIELD_W]);
    end

    AST_ONE_REG_PER_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q) $countones(changed) <= 1); // R8
    AST_CHANGE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q) (|changed) |-> ($past(poll_tick) && !$past(drdy_o))); // R5
    AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni) poll_tick |-> (gap_q == GAP_W'(POLL_TICKS - 1))); // R5
    AST_FALL_NEEDS_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(drdy_o) |-> $past(commit)); // R3
    AST_RISE_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(drdy_o) |-> $past(poll_tick)); // R4
    AST_WAIT_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) (!drdy_o && !poll_tick) |=> !drdy_o); // R4

endmodule

bind scp_cfg_port scp_cfg_port_chk #(
    .NUM_REGS  (NUM_REGS),
    .POLL_TICKS(POLL_TICKS)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .drdy_o   (drdy_o),
    .cfg_o    (cfg_o),
    .poll_tick(poll_tick),
    .commit   (commit)
);

// File: tb/tb_scp_cfg_port.sv
module tb_scp_cfg_port;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 6;
    localparam int FW         = 12;
    localparam int POLL       = 400;
    localparam logic [NREG*FW-1:0] DEFAULTS =
        {12'h5A0, 12'h0C3, 12'h214, 12'h008, 12'h3F0, 12'h101};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 strobe = 1'b0;
    logic                 data = 1'b0;
    logic                 drdy;
    logic [NREG*FW-1:0]   cfg;
    logic [NREG*FW-1:0]   model;

    int total = 0;
    int bad   = 0;
    int falls = 0;
    logic drdy_prev = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    scp_cfg_port #(
        .NUM_REGS  (NREG),
        .POLL_TICKS(POLL),
        .RESET_VALS(DEFAULTS)
    ) dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .strobe_i(strobe),
        .data_i  (data),
        .drdy_o  (drdy),
        .cfg_o   (cfg)
    );

    // Counts falling edges of the ready output, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && drdy_prev && !drdy) falls++;
        drdy_prev <= rst_n ? drdy : 1'b1;
    end

    task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse(input logic b, input int hi, input int lo);
        data = b;
        repeat (lo) @(negedge clk);
        strobe = 1'b1;
        repeat (hi) @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic send_bits(input logic [15:0] w, input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            pulse((i < 16) ? w[15 - i] : 1'b0, hi, lo);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!drdy && n < 2 * POLL) begin
            @(negedge clk);
            n++;
        end
        check(req, "ready returns within a poll period", 32'(drdy), 32'd1);
    endtask

    function automatic logic [15:0] mk(input logic [11:0] f, input logic [3:0] a);
        return {f, a};
    endfunction

    task automatic t_reset;
        check("R1", "registers at reset", 128'(cfg), 128'(DEFAULTS));
        check("R1", "ready at reset", 32'(drdy), 32'd1);
    endtask

    task automatic t_basic;
        int f0 = falls;
        send_bits(mk(12'hABC, 4'h2), 20, 4, 4);
        check("R4", "ready low while waiting", 32'(drdy), 32'd0);
        check("R5", "register untouched before poll", 32'(cfg[1*FW +: FW]), 32'(model[1*FW +: FW]));
        wait_ready("R4");
        @(negedge clk);
        model[1*FW +: FW] = 12'hABC;
        check("R2", "msb-first word lands in register 1", 32'(cfg[1*FW +: FW]), 32'h0ABC);
        check("R8", "other registers unchanged", 128'(cfg), 128'(model));
        check("R4", "one ready fall per word", 32'(falls - f0), 32'd1);
    endtask

    task automatic t_all_regs;
        for (int r = 0; r < NREG; r++) begin
            logic [11:0] v = 12'(12'h1F3 * (r + 3) ^ 12'h9A5);
            send_bits(mk(v, 4'(2 * r)), 20, 4, 4);
            wait_ready("R6");
            @(negedge clk);
            model[r*FW +: FW] = v;
            check("R6", $sformatf("address %0d selects register %0d", 2 * r, r), 128'(cfg), 128'(model));
        end
    endtask

    task automatic t_bad_addr;
        logic [3:0] addrs [3] = '{4'h3, 4'hC, 4'hE};
        for (int k = 0; k < 3; k++) begin
            int f0 = falls;
            send_bits(mk(12'hFFF, addrs[k]), 20, 4, 4);
            wait_ready("R6");
            @(negedge clk);
            check("R6", $sformatf("address %0h dropped", addrs[k]), 128'(cfg), 128'(model));
            check("R6", "ready still cycles on dropped word", 32'(falls - f0), 32'd1);
        end
    endtask

    task automatic t_trailing;
        int f0 = falls;
        send_bits(mk(12'h6D2, 4'h4), 19, 4, 4);
        repeat (POLL + 20) @(negedge clk);
        check("R3", "no commit after nineteen pulses", 32'(falls - f0), 32'd0);
        check("R3", "registers unchanged after nineteen pulses", 128'(cfg), 128'(model));
        pulse(1'b0, 4, 4);
        repeat (4) @(negedge clk);
        wait_ready("R3");
        @(negedge clk);
        model[2*FW +: FW] = 12'h6D2;
        check("R3", "twentieth pulse commits", 128'(cfg), 128'(model));
    endtask

    task automatic t_overwrite;
        int f0;
        // Align to the poll phase: a ready rise marks a tick.
        send_bits(mk(12'h0AA, 4'h8), 20, 4, 4);
        wait_ready("R7");
        @(negedge clk);
        model[4*FW +: FW] = 12'h0AA;
        f0 = falls;
        send_bits(mk(12'h777, 4'h6), 20, 4, 4);
        send_bits(mk(12'h999, 4'hA), 20, 4, 4);
        wait_ready("R7");
        @(negedge clk);
        model[5*FW +: FW] = 12'h999;
        check("R7", "later word wins, earlier word lost", 128'(cfg), 128'(model));
        check("R7", "single ready fall for both words", 32'(falls - f0), 32'd1);
    endtask

    task automatic t_slow;
        send_bits(mk(12'h5C3, 4'h0), 20, 30, 30);
        wait_ready("R9");
        @(negedge clk);
        model[0 +: FW] = 12'h5C3;
        check("R9", "slow strobe writes register 0", 128'(cfg), 128'(model));
    endtask

    initial begin
        repeat (1000000 / CLK_PERIOD) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model = DEFAULTS;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_all_regs();
        t_bad_addr();
        t_trailing();
        t_overwrite();
        t_slow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule